// File: doc/BRIEF.md
# Inter-Core Mailbox Register Bank

This block holds one 32-bit mailbox word for each (core, slot) pair. With the defaults there are four cores and four slots per core, so sixteen words. The cores use these words to signal one another. Each word can be reached through two address windows on a 32-bit word-access register bus:

- **Set window.** A write here ORs the data into the word. A read here returns zero.
- **Clear window.** A read here returns the word. A write here clears every bit that is 1 in the data.

Every mailbox drives one bit of a pending vector. That bit is high while the word holds any non-zero value. A downstream interrupt router turns slot `n` of a core into source bit 4+n of that core. Masking and routing are not part of this block.

The set window starts at byte 0x80 and the clear window at byte 0xC0. In each window, mailbox `i = 4*core + slot` sits at window base + 4*i. Both windows are aligned to their 64-byte span. Both writes and reads take effect at the clock edge where the request is sampled.

Top module: `mbox_bank`

## Requirements
- R1: After a synchronous active-low reset, all mailbox words are zero, `pending` is all zero and `bus_rdata` is zero.
- R2: A write at 0x80 + 4*i ORs `bus_wdata` into mailbox i, where i = 4*core + slot.
- R3: A write at 0xC0 + 4*i clears each bit of mailbox i that is 1 in `bus_wdata`, and leaves the other bits unchanged.
- R4: A read at 0xC0 + 4*i puts the current value of mailbox i on `bus_rdata` in the cycle after the request.
- R5: A read anywhere in the set window (0x80 to 0xBC) returns zero on `bus_rdata` in the cycle after the request.
- R6: `pending[i]` is 1 exactly when mailbox i is non-zero. It changes only in the cycle after a write that alters that word.
- R7: An access below 0x80, or an access whose address bits [1:0] are not 00, changes no mailbox. If it is a read, it returns zero.
- R8: A write to mailbox i leaves every other mailbox and its pending bit unchanged.
- R9: `bus_rdata` keeps its value in every cycle without a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read request |
| pending | output | 16 | Per-mailbox non-zero flag, bit i = mailbox 4*core+slot |

## Verification
A corrupted mailbox word shows up on the ports in two ways. Its pending bit disagrees with the model in the cycle after the write that caused the corruption. A read of the word in the clear window then returns the wrong value one cycle after the request. A decode fault that strikes the wrong word appears as a change in a neighbour's pending bit, checked on every write against a full model of all sixteen words. Stray and misaligned accesses are caught because the whole pending vector must stay unchanged after them and their reads must return zero.

// File: rtl/mbox_pkg.sv
// Package: shared sizes and types for the mailbox bank.
// Assumes: one bus access per cycle; windows aligned to their span.
package mbox_pkg;

    // Default geometry of the bank.
    localparam int unsigned DEF_CORES    = 4;
    localparam int unsigned DEF_SLOTS    = 4;
    localparam int unsigned DEF_DW       = 32;
    localparam int unsigned DEF_AW       = 8;
    localparam int unsigned DEF_SET_BASE = 'h80;
    localparam int unsigned DEF_CLR_BASE = 'hC0;

    // Window that an address decodes to.
    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_SET  = 2'd1,
        WIN_CLR  = 2'd2
    } mbox_win_e;

endpackage

// File: rtl/mbox_decode.sv
// Module: mbox_decode
// Decodes a byte address into a window (set, clear or none) and a mailbox
// index. Assumes each window base is aligned to its span of NUM*4 bytes,
// so the index is taken directly from address bits above the word offset.
// A misaligned address decodes to no window.
module mbox_decode
    import mbox_pkg::*;
#(
    parameter int unsigned AW       = DEF_AW,
    parameter int unsigned NUM      = 16,
    parameter int unsigned SET_BASE = DEF_SET_BASE,
    parameter int unsigned CLR_BASE = DEF_CLR_BASE,
    localparam int unsigned IDXW    = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic [AW-1:0]   addr,
    output mbox_win_e       win,
    output logic [IDXW-1:0] idx
);

    localparam int unsigned SPAN = NUM * 4;
    localparam logic [AW:0] SET_LO = (AW+1)'(SET_BASE);
    localparam logic [AW:0] SET_HI = (AW+1)'(SET_BASE + SPAN);
    localparam logic [AW:0] CLR_LO = (AW+1)'(CLR_BASE);
    localparam logic [AW:0] CLR_HI = (AW+1)'(CLR_BASE + SPAN);

    logic [AW:0] a_ext;
    logic        aligned;
    logic        in_set;
    logic        in_clr;

    // Range and alignment tests for both windows.
    always_comb begin
        a_ext   = {1'b0, addr};
        aligned = (addr[1:0] == 2'b00);
        in_set  = aligned && (a_ext >= SET_LO) && (a_ext < SET_HI);
        in_clr  = aligned && (a_ext >= CLR_LO) && (a_ext < CLR_HI);
    end

    // Window select; clear takes precedence if windows were ever to overlap.
    always_comb begin
        if (in_clr)      win = WIN_CLR;
        else if (in_set) win = WIN_SET;
        else             win = WIN_NONE;
    end

    // Mailbox index from the word offset bits.
    assign idx = addr[IDXW+1:2];

endmodule

// File: rtl/mbox_word.sv
// Module: mbox_word
// One mailbox register with OR-set and bit-clear updates plus a non-zero
// flag. Assumes at most one of set_en / clr_en per cycle from a single
// bus; if both occur, the clear is applied first and then the set.
module mbox_word #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic          clr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] value,
    output logic          nonzero
);

    logic [DW-1:0] word_q;
    logic [DW-1:0] word_d;
    logic [DW-1:0] clr_mask;
    logic [DW-1:0] set_mask;

    // Masks for this cycle's update.
    always_comb begin
        clr_mask = clr_en ? wdata : '0;
        set_mask = set_en ? wdata : '0;
        word_d   = (word_q & ~clr_mask) | set_mask;
    end

    // Word storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign value   = word_q;
    assign nonzero = |word_q;

endmodule

// File: rtl/mbox_readmux.sv
// Module: mbox_readmux
// Selects read data: the addressed word in the clear window, zero in any
// other window or for a stray address. Purely combinational.
module mbox_readmux
    import mbox_pkg::*;
#(
    parameter int unsigned DW   = 32,
    parameter int unsigned NUM  = 16,
    localparam int unsigned IDXW = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  mbox_win_e                win,
    input  logic [IDXW-1:0]          idx,
    input  logic [NUM-1:0][DW-1:0]   words,
    output logic [DW-1:0]            rdata
);

    // Word selection gated by the window.
    always_comb begin
        rdata = '0;
        if (win == WIN_CLR) begin
            for (int k = 0; k < NUM; k++) begin
                if (idx == IDXW'(k)) rdata = words[k];
            end
        end
    end

endmodule

// File: rtl/mbox_bank.sv
// Module: mbox_bank (top)
// Bank of CORES*SLOTS mailbox words with a set window, a clear/read window
// and a per-mailbox pending vector. Assumes word accesses only; one access
// per cycle; read data is registered and valid the cycle after a read.
module mbox_bank
    import mbox_pkg::*;
#(
    parameter int unsigned CORES    = DEF_CORES,
    parameter int unsigned SLOTS    = DEF_SLOTS,
    parameter int unsigned DW       = DEF_DW,
    parameter int unsigned AW       = DEF_AW,
    parameter int unsigned SET_BASE = DEF_SET_BASE,
    parameter int unsigned CLR_BASE = DEF_CLR_BASE
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_req,
    input  logic                   bus_we,
    input  logic [AW-1:0]          bus_addr,
    input  logic [DW-1:0]          bus_wdata,
    output logic [DW-1:0]          bus_rdata,
    output logic [CORES*SLOTS-1:0] pending
);

    localparam int unsigned NUM  = CORES * SLOTS;
    localparam int unsigned IDXW = (NUM > 1) ? $clog2(NUM) : 1;

    mbox_win_e               win;
    logic [IDXW-1:0]         idx;
    logic [NUM-1:0]          set_stb;
    logic [NUM-1:0]          clr_stb;
    logic [NUM-1:0][DW-1:0]  words;
    logic [DW-1:0]           rd_next;
    logic                    wr_go;
    logic                    rd_go;

    mbox_decode #(
        .AW(AW), .NUM(NUM), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
    ) u_dec (
        .addr (bus_addr),
        .win  (win),
        .idx  (idx)
    );

    // Qualify the bus request.
    always_comb begin
        wr_go = bus_req &&  bus_we;
        rd_go = bus_req && !bus_we;
    end

    // One-hot write strobes per mailbox.
    always_comb begin
        for (int k = 0; k < NUM; k++) begin
            set_stb[k] = wr_go && (win == WIN_SET) && (idx == IDXW'(k));
            clr_stb[k] = wr_go && (win == WIN_CLR) && (idx == IDXW'(k));
        end
    end

    for (genvar g = 0; g < NUM; g++) begin : g_word
        mbox_word #(.DW(DW)) u_word (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_en  (set_stb[g]),
            .clr_en  (clr_stb[g]),
            .wdata   (bus_wdata),
            .value   (words[g]),
            .nonzero (pending[g])
        );
    end

    mbox_readmux #(.DW(DW), .NUM(NUM)) u_rmux (
        .win   (win),
        .idx   (idx),
        .words (words),
        .rdata (rd_next)
    );

    // Read data register, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)     bus_rdata <= '0;
        else if (rd_go) bus_rdata <= rd_next;
    end

endmodule

// File: rtl/mbox_bank_chk.sv
// Module: mbox_bank_chk
// Assertion checker bound to mbox_bank; observes ports only and decodes
// addresses on its own.
module mbox_bank_chk #(
    parameter int unsigned CORES    = 4,
    parameter int unsigned SLOTS    = 4,
    parameter int unsigned DW       = 32,
    parameter int unsigned AW       = 8,
    parameter int unsigned SET_BASE = 'h80,
    parameter int unsigned CLR_BASE = 'hC0
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_req,
    input logic                   bus_we,
    input logic [AW-1:0]          bus_addr,
    input logic [DW-1:0]          bus_wdata,
    input logic [DW-1:0]          bus_rdata,
    input logic [CORES*SLOTS-1:0] pending
);

    localparam int NUM  = int'(CORES * SLOTS);
    localparam int IDXW = (NUM > 1) ? $clog2(NUM) : 1;

    int              a_int;
    logic            c_set;
    logic            c_clr;
    logic [IDXW-1:0] c_idx;

    // Independent address classification.
    always_comb begin
        a_int = int'(bus_addr);
        c_set = (a_int % 4 == 0) && a_int >= int'(SET_BASE) && a_int < int'(SET_BASE) + 4*NUM;
        c_clr = (a_int % 4 == 0) && a_int >= int'(CLR_BASE) && a_int < int'(CLR_BASE) + 4*NUM;
        c_idx = IDXW'((a_int / 4) % NUM);
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pending == '0));

    p_set_raises_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && c_set && bus_wdata != '0) |=> pending[$past(c_idx)]);

    p_clear_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && c_clr && bus_wdata == '1) |=> !pending[$past(c_idx)]);

    p_setwin_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && c_set) |=> (bus_rdata == '0));

    p_idle_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && bus_we) |=> $stable(pending));

    p_stray_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !c_set && !c_clr) |=> $stable(pending));

    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_we) |=> $stable(bus_rdata));

endmodule

bind mbox_bank mbox_bank_chk #(
    .CORES(CORES), .SLOTS(SLOTS), .DW(DW), .AW(AW),
    .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
) u_chk (.*);

// File: tb/mbox_bank_tb.sv
// Bench for mbox_bank: directed corners plus seeded random traffic,
// compared against a bench-side model of all mailbox words.
module mbox_bank_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NUM        = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pending;

    logic [31:0] model [NUM];
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    mbox_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pending(pending)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] set_addr(int i);
        return 8'(8'h80 + 4*i);
    endfunction

    function automatic logic [7:0] clr_addr(int i);
        return 8'(8'hC0 + 4*i);
    endfunction

    function automatic logic [15:0] exp_pending();
        logic [15:0] p;
        for (int k = 0; k < NUM; k++) p[k] = (model[k] != 0);
        return p;
    endfunction

    task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < NUM; k++) model[k] = '0;
    endtask

    // Write at a negedge; results visible at the following negedge.
    task automatic do_write(logic [7:0] a, logic [31:0] d, string req);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        if (a[1:0] == 2'b00 && a >= 8'h80) begin
            if (a < 8'hC0) model[a[5:2]] = model[a[5:2]] | d;
            else           model[a[5:2]] = model[a[5:2]] & ~d;
        end
        check32(req, 32'(pending), 32'(exp_pending()));
    endtask

    task automatic do_read(logic [7:0] a, logic [31:0] exp, string req);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_wdata = $urandom;
        @(negedge clk);
        bus_req = 1'b0;
        check32(req, bus_rdata, exp);
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        apply_reset();
        // R1: reset state
        check32("R1 pending", 32'(pending), 32'h0);
        check32("R1 rdata", bus_rdata, 32'h0);

        // R2/R6: set core 1 slot 2 (i=6); R8 others untouched
        do_write(set_addr(6), 32'h0000_00F0, "R2 R6 R8 set");
        do_write(set_addr(6), 32'h0F00_0001, "R2 OR-merge");
        do_read(clr_addr(6), 32'h0F00_00F1, "R4 readback");
        // R5: read in set window
        do_read(set_addr(6), 32'h0, "R5 set window read");
        // R9: rdata held when idle
        @(negedge clk);
        check32("R9 hold", bus_rdata, 32'h0);
        // R3: partial clear
        do_write(clr_addr(6), 32'h0000_00F0, "R3 partial clear");
        do_read(clr_addr(6), 32'h0F00_0001, "R3 R4 after clear");
        // R3/R6: full clear drops pending
        do_write(clr_addr(6), 32'hFFFF_FFFF, "R3 R6 full clear");
        // R7: stray and misaligned accesses
        do_write(set_addr(3), 32'h1, "R2 set i3");
        do_write(8'h40, 32'hFFFF_FFFF, "R7 low stray write");
        do_write(clr_addr(3) | 8'h1, 32'hFFFF_FFFF, "R7 misaligned clear");
        do_write(set_addr(9) | 8'h2, 32'h5, "R7 misaligned set");
        do_read(clr_addr(3) | 8'h3, 32'h0, "R7 misaligned read");
        do_read(8'h10, 32'h0, "R7 low stray read");
        do_read(clr_addr(3), 32'h1, "R7 R4 word intact");
        // Corners: last mailbox and first mailbox
        do_write(set_addr(15), 32'h8000_0000, "R2 R6 top index");
        do_write(set_addr(0), 32'hFFFF_FFFF, "R2 R6 index 0");
        do_read(clr_addr(15), 32'h8000_0000, "R4 top index");

        // Random traffic
        for (int n = 0; n < 2000; n++) begin
            int kind = int'($urandom % 6);
            int i    = int'($urandom % NUM);
            logic [31:0] d = (($urandom % 4) == 0) ? 32'hFFFF_FFFF : 32'($urandom);
            case (kind)
                0, 1: do_write(set_addr(i), d & 32'($urandom), "R2 R6 R8 random set");
                2:    do_write(clr_addr(i), d, "R3 R6 R8 random clear");
                3:    do_read(clr_addr(i), model[i], "R4 random read");
                4:    do_read(set_addr(i), 32'h0, "R5 random read");
                default: do_write(8'($urandom % 128), d, "R7 random stray");
            endcase
        end

        // R1: reset with content present
        do_write(set_addr(11), 32'h3, "R2 preload");
        apply_reset();
        check32("R1 pending after reset", 32'(pending), 32'h0);
        do_read(clr_addr(11), 32'h0, "R1 word after reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule